// File: doc/BRIEF.md
# Serial Receive Holding Buffer with Status Flags

This block sits between a serial shift engine and a register bus. Each time the engine finishes a word it raises a one-cycle completion pulse with the word. The block stores that word and sets a receive flag. If the stored word had not been read yet, the block also sets an overrun flag. Software reaches the block through a small read/write port. A read of the buffer location returns the word with both flags packed above it, and the read acknowledges all three: the word and both flags. A second location returns the same value with no side effect, so a debugger can look at it without consuming it.

An internal pending bit records that a stored word has not been read. This bit is not a flag. It survives when the module enable is dropped and raised again. For that reason, software should do a dummy read of the buffer after it re-enables the module, or the next word will be reported as an overrun. Each flag can be cleared in more than one way. Each flag has its own interrupt enable, and the single interrupt output combines the two enabled flags.

Top module: `spi_rxbuf_flags`

## Requirements
- R1: After synchronous reset, both flags, both interrupt enables, the stored word, the pending bit, `rd_data` and `irq` are zero.
- R2: A `word_done` pulse while `mod_en` is 1 stores `word_in` and sets the receive flag, both visible from the next cycle.
- R3: A word that completes while the pending bit is set, with no buffer read in the same cycle, sets the overrun flag and replaces the stored word.
- R4: A read of address 1 returns data in bits [DW-1:0], the receive flag at bit DW and the overrun flag at bit DW+1. It then clears both flags and the pending bit.
- R5: A read of address 2 returns the same layout as address 1 and changes no flag and no pending state.
- R6: Writing 1 to bit 4 of address 0, or to bit DW of address 1, clears the receive flag. Writing 1 to bit 5 of address 0, or to bit DW+1 of address 1, clears the overrun flag.
- R7: While `mod_en` is 0 the receive flag is held clear and completion pulses are ignored. The pending bit is kept, so the first word after re-enabling, with no read in between, sets the overrun flag.
- R8: When a set event and a clear event for the same flag fall in one cycle, the flag ends up set.
- R9: `irq` is (receive flag AND bit 0 of the control register) OR (overrun flag AND bit 1 of the control register). It changes on the same edge as the flags.
- R10: A read of address 0 returns the receive-interrupt enable at bit 0, the overrun-interrupt enable at bit 1, the receive flag at bit 4 and the overrun flag at bit 5, with all other bits zero. `rd_data` is registered: it takes the read value one edge after `rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable level |
| word_done | input | 1 | One-cycle pulse: a word has completed |
| word_in | input | DW | Completed word |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 buffer, 2 mirror |
| wr_data | input | RD_W | Write data |
| rd_data | output | RD_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the false overrun. It needs a word to stay unread across a drop and a restore of `mod_en`, which also clears the visible receive flag. The bench stores a word, drops the enable so the flag reads clear, sends a word while disabled to show that it is ignored, re-enables, and sends another word. The overrun must then appear, and a dummy read must keep it from coming back. Same-cycle collisions are driven as single cycles with two strobes active: a flag clear together with a completion, and a buffer read together with a completion.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_BUF  = 2'd1,
    A_MIR  = 2'd2,
    A_RSVD = 2'd3
  } rxb_addr_e;

  // control register bit positions
  localparam int CTL_RXIE = 0;
  localparam int CTL_OVIE = 1;
  localparam int CTL_RXF  = 4;
  localparam int CTL_OVF  = 5;

  typedef struct packed {
    logic       buf_rd;
    logic       clr_rx;
    logic       clr_ovr;
    logic       ctl_wr;
    logic [1:0] ctl_val;
  } rxb_cmd_t;

endpackage

// File: rtl/rxb_decode.sv
module rxb_decode
  import rxb_pkg::*;
#(
  parameter int DW   = 16,
  parameter int RD_W = 32
) (
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [RD_W-1:0] wr_data,
  output rxb_cmd_t        cmd
);
  localparam int RXF_IMG = DW;
  localparam int OVF_IMG = DW + 1;

  logic is_ctl, is_buf;
  logic unused_wbits;

  assign is_ctl       = (addr == A_CTRL);
  assign is_buf       = (addr == A_BUF);
  assign unused_wbits = ^wr_data;

  always_comb begin
    cmd         = '0;
    cmd.buf_rd  = rd_en && is_buf;
    cmd.clr_rx  = wr_en && ((is_ctl && wr_data[CTL_RXF]) ||
                            (is_buf && wr_data[RXF_IMG]));
    cmd.clr_ovr = wr_en && ((is_ctl && wr_data[CTL_OVF]) ||
                            (is_buf && wr_data[OVF_IMG]));
    cmd.ctl_wr  = wr_en && is_ctl;
    cmd.ctl_val = {wr_data[CTL_OVIE], wr_data[CTL_RXIE]};
  end
endmodule

// File: rtl/rxb_hold.sv
module rxb_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          consume,
  output logic [DW-1:0] dout,
  output logic          pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      pending <= 1'b0;
    end else begin
      if (load) dout <= din;
      if (load)         pending <= 1'b1;
      else if (consume) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/rxb_flags.sv
module rxb_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       mod_en,
  input  logic       load,
  input  logic       pending,
  input  logic       consume,
  input  logic       clr_rx,
  input  logic       clr_ovr,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_val,
  output logic       rx_flag,
  output logic       ovr_flag,
  output logic       rx_ie,
  output logic       ovr_ie,
  output logic       irq
);
  logic rx_nxt, ovr_nxt, rx_ie_nxt, ovr_ie_nxt, ovr_set;

  assign ovr_set = load && pending && !consume;

  always_comb begin
    rx_nxt = rx_flag;
    if (load)                           rx_nxt = 1'b1;
    else if (consume || clr_rx || !mod_en) rx_nxt = 1'b0;

    ovr_nxt = ovr_flag;
    if (ovr_set)                 ovr_nxt = 1'b1;
    else if (consume || clr_ovr) ovr_nxt = 1'b0;

    rx_ie_nxt  = ctl_wr ? ctl_val[0] : rx_ie;
    ovr_ie_nxt = ctl_wr ? ctl_val[1] : ovr_ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_flag  <= 1'b0;
      ovr_flag <= 1'b0;
      rx_ie    <= 1'b0;
      ovr_ie   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      rx_flag  <= rx_nxt;
      ovr_flag <= ovr_nxt;
      rx_ie    <= rx_ie_nxt;
      ovr_ie   <= ovr_ie_nxt;
      irq      <= (rx_nxt && rx_ie_nxt) || (ovr_nxt && ovr_ie_nxt);
    end
  end
endmodule

// File: rtl/rxb_readmux.sv
module rxb_readmux
  import rxb_pkg::*;
#(
  parameter int DW   = 16,
  parameter int RD_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   data,
  input  logic            rx_flag,
  input  logic            ovr_flag,
  input  logic            rx_ie,
  input  logic            ovr_ie,
  output logic [RD_W-1:0] rd_data
);
  logic [RD_W-1:0] mux_word;

  always_comb begin
    mux_word = '0;
    case (addr)
      A_CTRL: begin
        mux_word[CTL_RXIE] = rx_ie;
        mux_word[CTL_OVIE] = ovr_ie;
        mux_word[CTL_RXF]  = rx_flag;
        mux_word[CTL_OVF]  = ovr_flag;
      end
      A_BUF, A_MIR: begin
        mux_word[DW-1:0] = data;
        mux_word[DW]     = rx_flag;
        mux_word[DW+1]   = ovr_flag;
      end
      default: mux_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mux_word;
  end
endmodule

// File: rtl/spi_rxbuf_flags.sv
module spi_rxbuf_flags
  import rxb_pkg::*;
#(
  parameter int DW   = 16,
  parameter int RD_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mod_en,
  input  logic            word_done,
  input  logic [DW-1:0]   word_in,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [RD_W-1:0] wr_data,
  output logic [RD_W-1:0] rd_data,
  output logic            irq
);
  rxb_cmd_t      cmd;
  logic          load, pending, rx_flag, ovr_flag, rx_ie, ovr_ie;
  logic [DW-1:0] held;

  assign load = word_done && mod_en;

  rxb_decode #(.DW(DW), .RD_W(RD_W)) u_dec (
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .cmd(cmd)
  );

  rxb_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .load(load), .din(word_in),
    .consume(cmd.buf_rd), .dout(held), .pending(pending)
  );

  rxb_flags u_flags (
    .clk(clk), .rst(rst), .mod_en(mod_en), .load(load), .pending(pending),
    .consume(cmd.buf_rd), .clr_rx(cmd.clr_rx), .clr_ovr(cmd.clr_ovr),
    .ctl_wr(cmd.ctl_wr), .ctl_val(cmd.ctl_val),
    .rx_flag(rx_flag), .ovr_flag(ovr_flag), .rx_ie(rx_ie), .ovr_ie(ovr_ie),
    .irq(irq)
  );

  rxb_readmux #(.DW(DW), .RD_W(RD_W)) u_rmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .data(held),
    .rx_flag(rx_flag), .ovr_flag(ovr_flag), .rx_ie(rx_ie), .ovr_ie(ovr_ie),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker (
  input logic       clk,
  input logic       rst,
  input logic       mod_en,
  input logic       word_done,
  input logic       rd_en,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       rx_flag,
  input logic       ovr_flag,
  input logic       pending,
  input logic       rx_ie,
  input logic       ovr_ie,
  input logic       irq
);
  p_word_sets_rx_r2: assert property (@(posedge clk) disable iff (rst)
    (word_done && mod_en) |=> rx_flag);

  p_ovr_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> $past(word_done && mod_en && pending));

  p_buf_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd1 && !(word_done && mod_en)) |=>
      (!rx_flag && !ovr_flag && !pending));

  p_mirror_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == 2'd2 && !word_done && mod_en) |=>
      ($stable(rx_flag) && $stable(ovr_flag) && $stable(pending)));

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> !rx_flag);

  p_disable_keeps_pending_r7: assert property (@(posedge clk) disable iff (rst)
    (!mod_en && !rd_en) |=> $stable(pending));

  p_irq_combine_r9: assert property (@(posedge clk) disable iff (rst)
    irq == ((rx_flag && rx_ie) || (ovr_flag && ovr_ie)));
endmodule

bind spi_rxbuf_flags rxb_checker i_rxb_checker (
  .clk(clk), .rst(rst), .mod_en(mod_en), .word_done(word_done),
  .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rx_flag(rx_flag),
  .ovr_flag(ovr_flag), .pending(pending), .rx_ie(rx_ie), .ovr_ie(ovr_ie),
  .irq(irq)
);

// File: tb/test_spi_rxbuf_flags.sv
module test_spi_rxbuf_flags;
  localparam int DW   = 16;
  localparam int RD_W = 32;

  localparam logic [2:0] OP_WORD  = 3'd0;
  localparam logic [2:0] OP_WRCTL = 3'd1;
  localparam logic [2:0] OP_WRBUF = 3'd2;
  localparam logic [2:0] OP_RDCTL = 3'd3;
  localparam logic [2:0] OP_RDBUF = 3'd4;
  localparam logic [2:0] OP_RDMIR = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] wd;
    logic        chk;
    logic [31:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{OP_WRCTL, 32'h0000_0003, 1'b0, 32'h0,          1'b0}, // R9 enables only
    '{OP_WORD,  32'h0000_1234, 1'b0, 32'h0,          1'b1}, // R2 R9
    '{OP_RDMIR, 32'h0,         1'b1, 32'h0001_1234, 1'b1}, // R5
    '{OP_WORD,  32'h0000_ABCD, 1'b0, 32'h0,          1'b1}, // R3
    '{OP_RDMIR, 32'h0,         1'b1, 32'h0003_ABCD, 1'b1}, // R3 R5
    '{OP_RDBUF, 32'h0,         1'b1, 32'h0003_ABCD, 1'b0}, // R4
    '{OP_RDMIR, 32'h0,         1'b1, 32'h0000_ABCD, 1'b0}, // R4
    '{OP_WRCTL, 32'h0000_0001, 1'b0, 32'h0,          1'b0}, // R9
    '{OP_WORD,  32'h0000_0055, 1'b0, 32'h0,          1'b1}, // R2
    '{OP_WORD,  32'h0000_0066, 1'b0, 32'h0,          1'b1}, // R3
    '{OP_RDCTL, 32'h0,         1'b1, 32'h0000_0031, 1'b1}, // R10
    '{OP_WRCTL, 32'h0000_0021, 1'b0, 32'h0,          1'b1}, // R6 ctrl ovr clear
    '{OP_RDCTL, 32'h0,         1'b1, 32'h0000_0011, 1'b1}, // R6 R10
    '{OP_WRBUF, 32'h0001_0000, 1'b0, 32'h0,          1'b0}, // R6 buf rx clear
    '{OP_RDMIR, 32'h0,         1'b1, 32'h0000_0066, 1'b0}, // R6
    '{OP_WRCTL, 32'h0000_0002, 1'b0, 32'h0,          1'b0}, // R9
    '{OP_WORD,  32'h0000_0077, 1'b0, 32'h0,          1'b1}, // R3 R9
    '{OP_WRBUF, 32'h0002_0000, 1'b0, 32'h0,          1'b0}, // R6 buf ovr clear
    '{OP_RDBUF, 32'h0,         1'b1, 32'h0001_0077, 1'b0}  // R4 R6
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            mod_en = 1'b1;
  logic            word_done = 1'b0;
  logic [DW-1:0]   word_in = '0;
  logic            rd_en = 1'b0;
  logic            wr_en = 1'b0;
  logic [1:0]      addr = 2'd0;
  logic [RD_W-1:0] wr_data = '0;
  logic [RD_W-1:0] rd_data;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  spi_rxbuf_flags #(.DW(DW), .RD_W(RD_W)) i_spi_rxbuf_flags (
    .clk(clk), .rst(rst), .mod_en(mod_en), .word_done(word_done),
    .word_in(word_in), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
    word_done = 1'b0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setup(logic [2:0] op, logic [31:0] wd);
    case (op)
      OP_WORD:  begin word_done = 1'b1; word_in = wd[DW-1:0]; end
      OP_WRCTL: begin wr_en = 1'b1; addr = 2'd0; wr_data = wd; end
      OP_WRBUF: begin wr_en = 1'b1; addr = 2'd1; wr_data = wd; end
      OP_RDCTL: begin rd_en = 1'b1; addr = 2'd0; end
      OP_RDBUF: begin rd_en = 1'b1; addr = 2'd1; end
      OP_RDMIR: begin rd_en = 1'b1; addr = 2'd2; end
      default:  ;
    endcase
  endtask

  task automatic mirror(string req, logic [31:0] exp);
    setup(OP_RDMIR, 32'h0);
    tick();
    check(req, "mirror", rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    // R1: reset state
    check("R1", "rd_data", rd_data, 32'h0);
    check("R1", "irq", {31'h0, irq}, 32'h0);
    setup(OP_RDCTL, 32'h0); tick();
    check("R1", "ctrl", rd_data, 32'h0);
    mirror("R1", 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].op, VECS[i].wd);
      tick();
      if (VECS[i].chk) check("R2-table", $sformatf("vec %0d rd", i), rd_data, VECS[i].exp_rd);
      check("R9-table", $sformatf("vec %0d irq", i), {31'h0, irq}, {31'h0, VECS[i].exp_irq});
    end

    // R8: ctrl clear of rx with a completing word in the same cycle
    setup(OP_WRCTL, 32'h0000_0013);
    word_done = 1'b1; word_in = 16'h0101;
    tick();
    check("R8", "irq", {31'h0, irq}, 32'h1);
    mirror("R8", 32'h0001_0101);

    // R3/R8: buffer read with a completing word: old word returned, no overrun
    setup(OP_RDBUF, 32'h0);
    word_done = 1'b1; word_in = 16'h0202;
    tick();
    check("R3", "read old word", rd_data, 32'h0001_0101);
    mirror("R8", 32'h0001_0202);

    // R7: disable clears rx flag, ignores words, keeps pending
    mod_en = 1'b0;
    tick();
    check("R7", "irq disabled", {31'h0, irq}, 32'h0);
    setup(OP_WORD, 32'h0303);
    tick();
    mirror("R7", 32'h0000_0202);
    mod_en = 1'b1;
    setup(OP_WORD, 32'h0404);
    tick();
    mirror("R7", 32'h0003_0404);
    setup(OP_RDBUF, 32'h0); tick();
    check("R7", "dummy read", rd_data, 32'h0003_0404);
    setup(OP_WORD, 32'h0505); tick();
    mirror("R7", 32'h0001_0505);

    // R1: reset from a busy state
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1", "irq after reset", {31'h0, irq}, 32'h0);
    mirror("R1", 32'h0);
    setup(OP_RDCTL, 32'h0); tick();
    check("R10", "ctrl after reset", rd_data, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule